// File: doc/BRIEF.md
# External Bus Single-Cycle Sequencer with Acknowledge Pin Control

This block runs one read or write access at a time for a single chip-select channel of an external memory and peripheral bus. The internal side raises a request together with address, write data, direction and the channel settings: an acknowledge mode, a static/dynamic selector for the acknowledge pin, a wait count and a strobe-hold count. The block grants the request while idle, latches the settings for the whole access, and drives chip enable, output enable, write strobe, a 20-bit address and a 32-bit data bus. A one-cycle done pulse closes every access, and read data is valid at that pulse.

The acknowledge pin is shared and bidirectional. Its tri-state buffer is modelled as an output value, an output enable and an input. With internal acknowledge (Normal or Page mode) under the dynamic selector, the block drives the pin and marks the data point with a one-clock low strobe. With external acknowledge (External ACK or Ready mode), the block releases the pin for the length of the access and waits for the external device to pull it low. Under the static selector, the pin is never driven.

Top module: `xbus_seq`

## Requirements
- R1: After reset the bus is idle: `ce_n`, `oe_n` and `we_n` are high, `done` is low, `ack_out_n` is high, and `ack_oe` equals `ack_dyn`.
- R2: With `ack_dyn` = 0 (static), `ack_oe` stays 0 in every cycle.
- R3: Modes 0 (Normal) and 1 (Page) use internal acknowledge. An access starts in the cycle after the grant (cycle 0, `ce_n` low). `ack_out_n` is low only in cycle `wait_cnt`+1, which is the transfer cycle T. Under `ack_dyn` = 1, `ack_oe` is 1 throughout.
- R4: Modes 2 (External ACK) and 3 (Ready) under `ack_dyn` = 1: `ack_oe` is 0 from the first cycle with `ce_n` low through the first cycle with `ce_n` high again, and is 1 in the cycle after that.
- R5: In modes 2 and 3, the transfer cycle T is the first cycle t ≥ `wait_cnt` in which `ack_in_n` is sampled low. In modes 0 and 1, `ack_in_n` has no effect on timing.
- R6: On a read, `rdata` takes the value on `bus_din` at the clock edge that ends cycle T. `oe_n` is low from cycle 0 through cycle T+`hold_cnt`. `done` pulses in cycle T+`hold_cnt`+1, and `ce_n` rises in the cycle after that.
- R7: On a write, `we_n` is low from cycle 0 through cycle T+`hold_cnt`+1. `bus_doe` stays 1 for one more cycle, in which `done` pulses, and `ce_n` rises in the cycle after that.
- R8: `oe_n` is never low during a write, and `bus_addr` and `bus_dout` hold the latched request values for the whole access.
- R9: `gnt` equals `req` while idle and is 0 otherwise. Each access produces exactly one single-cycle `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Access address |
| req_wdata | input | 32 | Write data |
| ack_mode | input | 2 | 0 Normal, 1 Page, 2 External ACK, 3 Ready |
| ack_dyn | input | 1 | 1 = dynamic pin direction, 0 = pin always input |
| wait_cnt | input | 4 | Wait count before the transfer point |
| hold_cnt | input | 4 | Strobe-hold cycles after the transfer point |
| gnt | output | 1 | Request accepted this cycle |
| done | output | 1 | One-cycle access completion |
| rdata | output | 32 | Captured read data |
| ce_n | output | 1 | Chip enable, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write strobe, active low |
| bus_addr | output | 20 | External address |
| bus_dout | output | 32 | External data out |
| bus_doe | output | 1 | External data drive enable |
| bus_din | input | 32 | External data in |
| ack_out_n | output | 1 | Acknowledge pin output value |
| ack_oe | output | 1 | Acknowledge pin drive enable |
| ack_in_n | input | 1 | Acknowledge pin input value |

## Verification
The assertions check properties that must hold in every cycle. The pin is never driven under the static selector. It is released while an externally acknowledged access is active and in the first idle cycle after it. The internal acknowledge strobe and `done` each last one cycle, `ce_n` rises after `done`, output enable never overlaps a write, and data stays driven in the cycle where the write strobe rises. The bench scenarios are needed for the properties that depend on counts and data. These are the exact transfer cycle computed from the wait count and the external acknowledge delay, the strobe-hold stretch, the captured read word, and the fact that the acknowledge input is ignored in the internal modes.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_ACK,
    S_HOLD,
    S_WEND,
    S_RTAIL,
    S_DHOLD
  } seq_st_t;

  localparam logic [1:0] MODE_NORMAL = 2'd0;
  localparam logic [1:0] MODE_PAGE   = 2'd1;
  localparam logic [1:0] MODE_EXTACK = 2'd2;
  localparam logic [1:0] MODE_READY  = 2'd3;

  function automatic logic mode_is_ext(input logic [1:0] m);
    return (m == MODE_EXTACK) || (m == MODE_READY);
  endfunction

endpackage

// File: rtl/xbus_ctl.sv
module xbus_ctl
  import xbus_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          we_l,
  input  logic          ext_l,
  input  logic [CW-1:0] wait_l,
  input  logic [CW-1:0] hold_l,
  input  logic          ack_in_n,
  output seq_st_t       st,
  output logic          xfer
);

  seq_st_t       st_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic          cnt_en;
  seq_st_t       post_xfer_st;

  // State that follows the transfer point, skipping HOLD when no hold is set
  always_comb begin
    if (hold_l != '0)  post_xfer_st = S_HOLD;
    else if (we_l)     post_xfer_st = S_WEND;
    else               post_xfer_st = S_RTAIL;
  end

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    cnt_en = 1'b0;
    xfer   = 1'b0;
    unique case (st)
      S_IDLE: begin
        if (start) begin
          st_nx  = S_WAIT;
          cnt_nx = '0;
          cnt_en = 1'b1;
        end
      end
      S_WAIT: begin
        if (cnt == wait_l) begin
          if (!ext_l) begin
            st_nx = S_ACK;
          end else if (!ack_in_n) begin
            xfer   = 1'b1;
            st_nx  = post_xfer_st;
            cnt_nx = CW'(1);
            cnt_en = 1'b1;
          end
        end else begin
          cnt_nx = cnt + 1'b1;
          cnt_en = 1'b1;
        end
      end
      S_ACK: begin
        xfer   = 1'b1;
        st_nx  = post_xfer_st;
        cnt_nx = CW'(1);
        cnt_en = 1'b1;
      end
      S_HOLD: begin
        if (cnt == hold_l) begin
          st_nx = we_l ? S_WEND : S_RTAIL;
        end else begin
          cnt_nx = cnt + 1'b1;
          cnt_en = 1'b1;
        end
      end
      S_WEND:  st_nx = S_DHOLD;
      S_RTAIL: st_nx = S_IDLE;
      S_DHOLD: st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= st_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nx;
  end

endmodule

// File: rtl/xbus_dpath.sv
module xbus_dpath #(
  parameter int AW = 20,
  parameter int DW = 32,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cap_en,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    ack_mode,
  input  logic          ack_dyn,
  input  logic [CW-1:0] wait_cnt,
  input  logic [CW-1:0] hold_cnt,
  input  logic [DW-1:0] bus_din,
  output logic          we_l,
  output logic          ext_l,
  output logic          dyn_l,
  output logic [CW-1:0] wait_l,
  output logic [CW-1:0] hold_l,
  output logic [AW-1:0] addr_l,
  output logic [DW-1:0] wdata_l,
  output logic [DW-1:0] rdata
);

  import xbus_pkg::mode_is_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_l    <= 1'b0;
      ext_l   <= 1'b0;
      dyn_l   <= 1'b0;
      wait_l  <= '0;
      hold_l  <= '0;
      addr_l  <= '0;
      wdata_l <= '0;
    end else if (start) begin
      we_l    <= req_we;
      ext_l   <= mode_is_ext(ack_mode);
      dyn_l   <= ack_dyn;
      wait_l  <= wait_cnt;
      hold_l  <= hold_cnt;
      addr_l  <= req_addr;
      wdata_l <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (cap_en) rdata <= bus_din;
  end

endmodule

// File: rtl/xbus_ackpin.sv
module xbus_ackpin
  import xbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  seq_st_t st,
  input  logic    dyn_l,
  input  logic    ext_l,
  input  logic    dyn_in,
  input  logic    last_cyc,
  output logic    ack_oe,
  output logic    ack_out_n
);

  logic busy;
  logic rel_tail;

  assign busy = (st != S_IDLE);

  // Keep the pin released for one idle cycle after an externally acknowledged access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_tail <= 1'b0;
    else        rel_tail <= last_cyc & ext_l;
  end

  always_comb begin
    if (busy) ack_oe = dyn_l & ~ext_l;
    else      ack_oe = dyn_in & ~rel_tail;
  end

  assign ack_out_n = (st != S_ACK);

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 32,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    ack_mode,
  input  logic          ack_dyn,
  input  logic [CW-1:0] wait_cnt,
  input  logic [CW-1:0] hold_cnt,
  output logic          gnt,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  input  logic [DW-1:0] bus_din,
  output logic          ack_out_n,
  output logic          ack_oe,
  input  logic          ack_in_n
);

  seq_st_t       st;
  logic          xfer;
  logic          start;
  logic          we_l, ext_l, dyn_l;
  logic [CW-1:0] wait_l, hold_l;
  logic          pre_xfer;

  assign gnt   = req & (st == S_IDLE);
  assign start = gnt;

  xbus_ctl #(.CW(CW)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .we_l     (we_l),
    .ext_l    (ext_l),
    .wait_l   (wait_l),
    .hold_l   (hold_l),
    .ack_in_n (ack_in_n),
    .st       (st),
    .xfer     (xfer)
  );

  xbus_dpath #(.AW(AW), .DW(DW), .CW(CW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cap_en    (xfer & ~we_l),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ack_mode  (ack_mode),
    .ack_dyn   (ack_dyn),
    .wait_cnt  (wait_cnt),
    .hold_cnt  (hold_cnt),
    .bus_din   (bus_din),
    .we_l      (we_l),
    .ext_l     (ext_l),
    .dyn_l     (dyn_l),
    .wait_l    (wait_l),
    .hold_l    (hold_l),
    .addr_l    (bus_addr),
    .wdata_l   (bus_dout),
    .rdata     (rdata)
  );

  assign done = (st == S_RTAIL) || (st == S_DHOLD);

  xbus_ackpin u_ack (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .dyn_l     (dyn_l),
    .ext_l     (ext_l),
    .dyn_in    (ack_dyn),
    .last_cyc  (done),
    .ack_oe    (ack_oe),
    .ack_out_n (ack_out_n)
  );

  // Strobes stay active through the transfer point and the hold cycles
  assign pre_xfer = (st == S_WAIT) || (st == S_ACK) || (st == S_HOLD);
  assign ce_n     = (st == S_IDLE);
  assign oe_n     = ~(pre_xfer & ~we_l);
  assign we_n     = ~(we_l & (pre_xfer || (st == S_WEND)));
  assign bus_doe  = we_l & (st != S_IDLE);

endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic done,
  input logic bus_doe,
  input logic ack_oe,
  input logic ack_out_n,
  input logic ack_dyn,
  input logic dyn_l,
  input logic ext_l
);

  assert_static_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !ack_dyn) |-> !ack_oe);

  assert_static_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !dyn_l) |-> !ack_oe);

  assert_ext_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && ext_l) |-> !ack_oe);

  assert_ext_tail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ce_n) && ext_l) |-> !ack_oe);

  assert_ack_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_out_n |=> ack_out_n);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && ce_n));

  assert_no_oe_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!ce_n && we_n));

  assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(we_n) && !ce_n) |-> bus_doe);

endmodule

bind xbus_seq xbus_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ce_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .done      (done),
  .bus_doe   (bus_doe),
  .ack_oe    (ack_oe),
  .ack_out_n (ack_out_n),
  .ack_dyn   (ack_dyn),
  .dyn_l     (dyn_l),
  .ext_l     (ext_l)
);

// File: tb/xbus_seq_tb.sv
module xbus_seq_tb;

  logic        clk;
  logic        rst_n;
  logic        req, req_we;
  logic [19:0] req_addr;
  logic [31:0] req_wdata;
  logic [1:0]  ack_mode;
  logic        ack_dyn;
  logic [3:0]  wait_cnt, hold_cnt;
  logic        gnt, done;
  logic [31:0] rdata;
  logic        ce_n, oe_n, we_n;
  logic [19:0] bus_addr;
  logic [31:0] bus_dout;
  logic        bus_doe;
  logic [31:0] bus_din;
  logic        ack_out_n, ack_oe, ack_in_n;

  int n_chk;
  int n_fail;

  xbus_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack_mode(ack_mode), .ack_dyn(ack_dyn),
    .wait_cnt(wait_cnt), .hold_cnt(hold_cnt), .gnt(gnt), .done(done),
    .rdata(rdata), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
    .ack_out_n(ack_out_n), .ack_oe(ack_oe), .ack_in_n(ack_in_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", rq, what, act, exp, $time);
    end
  endtask

  function automatic int xfer_cycle(input bit ext, input int w, input int d);
    if (ext) return (d > w) ? d : w;
    return w + 1;
  endfunction

  // One access; d is the cycle from which the external acknowledge is held low
  task automatic run_txn(input bit we, input logic [19:0] a, input logic [31:0] wd,
                         input logic [1:0] m, input bit dyn, input int w, input int h,
                         input int d, input logic [31:0] din_base);
    bit ext;
    int t_x, last;
    ext  = m[1];
    t_x  = xfer_cycle(ext, w, d);
    last = we ? t_x + h + 2 : t_x + h + 1;
    @(negedge clk);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
    ack_mode = m; ack_dyn = dyn; wait_cnt = 4'(w); hold_cnt = 4'(h);
    #1;
    chk("R9", "gnt idle", 32'(gnt), 32'd1);
    @(negedge clk);
    req = 1'b0;
    req_addr = ~a; req_wdata = ~wd; wait_cnt = 4'd0; hold_cnt = 4'd0;
    for (int t = 0; t <= last + 2; t++) begin
      // internal modes see a permanently low acknowledge input: it must not matter (R5)
      ack_in_n = ext ? ((t >= d) ? 1'b0 : 1'b1) : 1'b0;
      bus_din  = din_base + 32'(t);
      #1;
      if (t <= last) begin
        chk("R9", "ce_n active", 32'(ce_n), 32'd0);
        chk("R9", "done", 32'(done), 32'(t == last));
        chk("R9", "gnt busy", 32'(gnt), 32'd0);
        chk("R3", "ack_out_n", 32'(ack_out_n), 32'(!( !ext && t == t_x)));
        chk(ext ? "R4" : "R3", "ack_oe busy", 32'(ack_oe), 32'(dyn && !ext));
        chk("R8", "bus_addr", 32'(bus_addr), 32'(a));
        chk("R7", "bus_doe", 32'(bus_doe), 32'(we));
        if (we) begin
          chk("R7", "we_n", 32'(we_n), 32'(t > t_x + h + 1));
          chk("R8", "oe_n write", 32'(oe_n), 32'd1);
          chk("R8", "bus_dout", bus_dout, wd);
        end else begin
          chk("R6", "oe_n", 32'(oe_n), 32'(t > t_x + h));
          chk("R6", "we_n read", 32'(we_n), 32'd1);
        end
        if (t == last && !we)
          chk(ext ? "R5" : "R6", "rdata", rdata, din_base + 32'(t_x));
      end else begin
        chk(we ? "R7" : "R6", "ce_n end", 32'(ce_n), 32'd1);
        chk("R9", "done idle", 32'(done), 32'd0);
        if (t == last + 1)
          chk(dyn ? "R4" : "R2", "ack_oe tail", 32'(ack_oe), 32'(dyn && !ext));
        else
          chk("R4", "ack_oe idle", 32'(ack_oe), 32'(dyn));
      end
      @(negedge clk);
    end
    ack_in_n = 1'b1;
  endtask

  bit finished;

  initial begin
    finished = 1'b0;
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0;
    void'($urandom(32'd2024));
    rst_n = 1'b0; req = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    ack_mode = 2'd0; ack_dyn = 1'b1; wait_cnt = 4'd2; hold_cnt = 4'd0;
    bus_din = '0; ack_in_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1", "ce_n", 32'(ce_n), 32'd1);
    chk("R1", "oe_n", 32'(oe_n), 32'd1);
    chk("R1", "we_n", 32'(we_n), 32'd1);
    chk("R1", "done", 32'(done), 32'd0);
    chk("R1", "ack_out_n", 32'(ack_out_n), 32'd1);
    chk("R1", "ack_oe", 32'(ack_oe), 32'd1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // directed corners
    run_txn(1'b0, 20'h12345, 32'h0,        2'd0, 1'b1, 2, 0, 0, 32'hA000_0000);
    run_txn(1'b1, 20'h0ABCD, 32'hDEADBEEF, 2'd1, 1'b1, 2, 0, 0, 32'h0);
    run_txn(1'b0, 20'hFFFFF, 32'h0,        2'd2, 1'b1, 0, 0, 9, 32'hB000_0000);
    run_txn(1'b1, 20'h00001, 32'h13572468, 2'd3, 1'b1, 3, 2, 1, 32'h0);
    run_txn(1'b0, 20'h54321, 32'h0,        2'd0, 1'b0, 0, 3, 0, 32'hC000_0000);
    run_txn(1'b1, 20'h11111, 32'hCAFEF00D, 2'd2, 1'b0, 1, 0, 4, 32'h0);
    run_txn(1'b0, 20'h22222, 32'h0,        2'd3, 1'b1, 4, 1, 4, 32'hD000_0000);
    // random mix
    for (int i = 0; i < 60; i++) begin
      run_txn(1'($urandom), 20'($urandom), $urandom, 2'($urandom), 1'($urandom),
              int'($urandom % 6), int'($urandom % 4), int'($urandom % 9), $urandom);
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule